// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Port

This block is the configuration front end of a system chipset. Software reaches a bank of 256 byte-wide registers through two adjacent byte-wide I/O addresses. A write to the lower address (0xF2) loads an index. A write to the upper address (0xF3) stores a byte into the register that the index selects. Before the byte is stored, a write mask that belongs to that register is applied. Reads of either address return the index or the selected register, and a read changes nothing.

A few registers drive chipset functions directly:

- One register enables shadow RAM for five regions of the upper-memory BIOS area. It also holds a write-protect bit that covers all five regions.
- Two other registers drive the external-cache and internal-cache enables.
- A write to any of the three timing registers (0x01, 0x04, 0x1A) raises a one-cycle wait-state update strobe.

A combinational lookup port takes a 20-bit memory address and reports whether that address reads from internal RAM and whether writes to it reach internal RAM.

Top module: `cfgport_top`

## Requirements
- R1: A write to I/O address 0xF2 loads the index. A read of 0xF2 returns the index unchanged.
- R2: A read of I/O address 0xF3 returns the register selected by the current index.
- R3: A write to 0xF3 stores the byte ANDed with a per-register mask:
  - 0x01 uses 0xD3.
  - 0x02 uses 0x7F.
  - 0x03, 0x06 and 0x07 use 0x1F.
  - 0x05 uses 0xF3.
  - 0x08 uses 0x0F.
  - 0x09 uses 0x03.
  - 0x12 uses 0xBB.
  - 0x18 uses 0x77.
  - 0x19 uses 0xFB.
  - 0x1B uses 0xEF.
- R4: Every other index stores the full byte. This covers 0x00, 0x04, 0x0A–0x11, 0x1A and all indices without a rule.
- R5: Reset clears the index and all 256 registers to zero.
- R6: Bits 0 to 4 of register 0x02 each enable shadow reads from internal RAM for one region. The regions are:
  - bit 0: 0xC0000–0xC7FFF
  - bit 1: 0xC8000–0xCFFFF
  - bit 2: 0xD0000–0xDFFFF
  - bit 3: 0xE0000–0xEFFFF
  - bit 4: 0xF0000–0xFFFFF
- R7: An enabled region accepts internal writes only while bit 5 of register 0x02 is clear. A disabled region reports neither internal reads nor internal writes.
- R8: The external-cache enable equals bit 0 of register 0x04. The internal-cache enable equals the inverse of bit 6 of register 0x1A.
- R9: A data write to register 0x01, 0x04 or 0x1A makes the wait-state strobe high for exactly the one cycle after the write edge. No other write raises it.
- R10: For a lookup address below 0xC0000, both lookup flags read 0.
- R11: A write to the index port leaves every register unchanged. Writes to other I/O addresses change nothing, and reads of other addresses return 0.
- R12: Reads have no side effects: repeated reads return the same value and leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 8 | I/O write data |
| ioWr | input | 1 | I/O write strobe, committed at the clock edge |
| ioRd | input | 1 | I/O read strobe |
| ioRdData | output | 8 | Read data, combinational; 0 when not decoded |
| extCacheEn | output | 1 | External cache enable |
| intCacheEn | output | 1 | Internal cache enable |
| shadowRdInt | output | 5 | Per-region internal-read attribute |
| shadowWrInt | output | 5 | Per-region internal-write attribute |
| waitUpdate | output | 1 | One-cycle wait-state recalculation strobe |
| lookupAddr | input | 20 | Memory address to classify |
| lookupRdInt | output | 1 | Lookup address reads internal RAM |
| lookupWrInt | output | 1 | Lookup address writes internal RAM |

## Verification
The bench builds the block with its default parameters: an 8-bit index, which gives 256 registers, and five shadow regions. With these values the whole index space is within reach. After reset the bench reads back every register. It then covers every masked register, the gaps between them, and the highest index 0xFF. It also probes both edges of every region, including the 32 KB regions, where address bit 15 alone selects between the two halves.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic rdIdx;
    logic rdData;
  } cfgStrobe_t;

  // Per-register write mask; indices without a rule keep all bits.
  function automatic logic [7:0] writeMask(input logic [7:0] idx);
    logic [7:0] m;
    case (idx)
      8'h01:               m = 8'hD3;
      8'h02:               m = 8'h7F;
      8'h03, 8'h06, 8'h07: m = 8'h1F;
      8'h05:               m = 8'hF3;
      8'h08:               m = 8'h0F;
      8'h09:               m = 8'h03;
      8'h12:               m = 8'hBB;
      8'h18:               m = 8'h77;
      8'h19:               m = 8'hFB;
      8'h1B:               m = 8'hEF;
      default:             m = 8'hFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h00F2,
  parameter logic [IDX_W-1:0] WAIT_IDX_A = 8'h01,
  parameter logic [IDX_W-1:0] WAIT_IDX_B = 8'h04,
  parameter logic [IDX_W-1:0] WAIT_IDX_C = 8'h1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [IDX_W-1:0]  curIdx,
  output cfgStrobe_t        strb,
  output logic              waitUpdate
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = IDX_ADDR + 1'b1;

  logic hitIdx, hitData, waitIdx;

  always_comb begin
    hitIdx      = (ioAddr == IDX_ADDR);
    hitData     = (ioAddr == DATA_ADDR);
    strb.idxWr  = ioWr & hitIdx;
    strb.dataWr = ioWr & hitData;
    strb.rdIdx  = ioRd & hitIdx;
    strb.rdData = ioRd & hitData;
    waitIdx     = (curIdx == WAIT_IDX_A) || (curIdx == WAIT_IDX_B) ||
                  (curIdx == WAIT_IDX_C);
  end

  always_ff @(posedge clk) begin
    if (!rstN) waitUpdate <= 1'b0;
    else       waitUpdate <= strb.dataWr & waitIdx;
  end

endmodule

// File: rtl/cfgport_datapath.sv
module cfgport_datapath
  import cfgport_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 20,
  parameter int NUM_REGIONS = 5,
  parameter int NUM_SMALL = 2,
  parameter logic [MEM_AW-1:0] SHADOW_BASE = 20'hC0000,
  parameter logic [MEM_AW-1:0] SMALL_SZ = 20'h08000,
  parameter logic [MEM_AW-1:0] LARGE_SZ = 20'h10000,
  parameter logic [IDX_W-1:0] SHADOW_REG = 8'h02,
  parameter int WP_BIT = 5,
  parameter logic [IDX_W-1:0] EXTC_REG = 8'h04,
  parameter int EXTC_BIT = 0,
  parameter logic [IDX_W-1:0] INTC_REG = 8'h1A,
  parameter int INTC_BIT = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfgStrobe_t             strb,
  input  logic [DATA_W-1:0]      ioWrData,
  output logic [IDX_W-1:0]       curIdx,
  output logic [DATA_W-1:0]      ioRdData,
  output logic                   extCacheEn,
  output logic                   intCacheEn,
  output logic [NUM_REGIONS-1:0] shadowRdInt,
  output logic [NUM_REGIONS-1:0] shadowWrInt,
  input  logic [MEM_AW-1:0]      lookupAddr,
  output logic                   lookupRdInt,
  output logic                   lookupWrInt
);

  localparam int NUM_REGS = 1 << IDX_W;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] shadowCtl;

  assign curIdx = idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (strb.idxWr) idxQ <= ioWrData[IDX_W-1:0];
      if (strb.dataWr) regFile[idxQ] <= ioWrData & writeMask(idxQ);
    end
  end

  always_comb begin
    if (strb.rdIdx)       ioRdData = DATA_W'(idxQ);
    else if (strb.rdData) ioRdData = regFile[idxQ];
    else                  ioRdData = '0;
  end

  assign shadowCtl  = regFile[SHADOW_REG];
  assign extCacheEn = regFile[EXTC_REG][EXTC_BIT];
  assign intCacheEn = ~regFile[INTC_REG][INTC_BIT];

  logic [NUM_REGIONS-1:0] regionHit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    localparam logic [MEM_AW:0] BASE = (g < NUM_SMALL)
      ? ({1'b0, SHADOW_BASE} + g * {1'b0, SMALL_SZ})
      : ({1'b0, SHADOW_BASE} + NUM_SMALL * {1'b0, SMALL_SZ} +
         (g - NUM_SMALL) * {1'b0, LARGE_SZ});
    localparam logic [MEM_AW:0] LAST = BASE +
      ((g < NUM_SMALL) ? {1'b0, SMALL_SZ} : {1'b0, LARGE_SZ}) - 1'b1;

    assign shadowRdInt[g] = shadowCtl[g];
    assign shadowWrInt[g] = shadowCtl[g] & ~shadowCtl[WP_BIT];
    assign regionHit[g]   = ({1'b0, lookupAddr} >= BASE) &&
                            ({1'b0, lookupAddr} <= LAST);
  end

  assign lookupRdInt = |(regionHit & shadowRdInt);
  assign lookupWrInt = |(regionHit & shadowWrInt);

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 20,
  parameter int NUM_REGIONS = 5,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h00F2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      ioAddr,
  input  logic [DATA_W-1:0]      ioWrData,
  input  logic                   ioWr,
  input  logic                   ioRd,
  output logic [DATA_W-1:0]      ioRdData,
  output logic                   extCacheEn,
  output logic                   intCacheEn,
  output logic [NUM_REGIONS-1:0] shadowRdInt,
  output logic [NUM_REGIONS-1:0] shadowWrInt,
  output logic                   waitUpdate,
  input  logic [MEM_AW-1:0]      lookupAddr,
  output logic                   lookupRdInt,
  output logic                   lookupWrInt
);

  cfgStrobe_t      strb;
  logic [IDX_W-1:0] curIdx;

  cfgport_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_ADDR(IDX_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .curIdx(curIdx), .strb(strb), .waitUpdate(waitUpdate)
  );

  cfgport_datapath #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .NUM_REGIONS(NUM_REGIONS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWrData(ioWrData), .curIdx(curIdx),
    .ioRdData(ioRdData), .extCacheEn(extCacheEn), .intCacheEn(intCacheEn),
    .shadowRdInt(shadowRdInt), .shadowWrInt(shadowWrInt),
    .lookupAddr(lookupAddr), .lookupRdInt(lookupRdInt), .lookupWrInt(lookupWrInt)
  );

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 20,
  parameter int NUM_REGIONS = 5,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h00F2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      ioAddr,
  input logic                   ioWr,
  input logic                   extCacheEn,
  input logic                   intCacheEn,
  input logic [NUM_REGIONS-1:0] shadowRdInt,
  input logic [NUM_REGIONS-1:0] shadowWrInt,
  input logic                   waitUpdate,
  input logic [MEM_AW-1:0]      lookupAddr,
  input logic                   lookupRdInt,
  input logic                   lookupWrInt
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = IDX_ADDR + 1'b1;
  localparam logic [MEM_AW-1:0] WIN_LO = 20'hC0000;

  // R9: the strobe only follows a data-port write
  a_r9_strobe_after_data_write: assert property (@(posedge clk) disable iff (!rstN)
    waitUpdate |-> $past(ioWr && (ioAddr == DATA_ADDR)));

  // R7: internal write never granted without internal read on the same region
  a_r7_write_within_read: assert property (@(posedge clk) disable iff (!rstN)
    (shadowWrInt & ~shadowRdInt) == '0);

  // R11: index writes and foreign writes leave the shadow attributes alone
  a_r11_shadow_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr && (ioAddr == DATA_ADDR)) |-> $stable(shadowRdInt) && $stable(shadowWrInt));

  // R8: cache enables move only after a data-port write
  a_r8_cache_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr && (ioAddr == DATA_ADDR)) |-> $stable(extCacheEn) && $stable(intCacheEn));

  // R10: below the shadow window nothing is internal
  a_r10_below_window: assert property (@(posedge clk) disable iff (!rstN)
    (lookupAddr < WIN_LO) |-> !lookupRdInt && !lookupWrInt);

endmodule

bind cfgport_top cfgport_checker #(
  .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .NUM_REGIONS(NUM_REGIONS), .IDX_ADDR(IDX_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr),
  .extCacheEn(extCacheEn), .intCacheEn(intCacheEn),
  .shadowRdInt(shadowRdInt), .shadowWrInt(shadowWrInt), .waitUpdate(waitUpdate),
  .lookupAddr(lookupAddr), .lookupRdInt(lookupRdInt), .lookupWrInt(lookupWrInt)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] ioAddr;
  logic [7:0]  ioWrData;
  logic        ioWr, ioRd;
  logic [7:0]  ioRdData;
  logic        extCacheEn, intCacheEn, waitUpdate;
  logic [4:0]  shadowRdInt, shadowWrInt;
  logic [19:0] lookupAddr;
  logic        lookupRdInt, lookupWrInt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  cfgport_top dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRd(ioRd), .ioRdData(ioRdData), .extCacheEn(extCacheEn),
    .intCacheEn(intCacheEn), .shadowRdInt(shadowRdInt), .shadowWrInt(shadowWrInt),
    .waitUpdate(waitUpdate), .lookupAddr(lookupAddr), .lookupRdInt(lookupRdInt),
    .lookupWrInt(lookupWrInt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Mask table taken from R3; unlisted indices keep all bits (R4)
  function automatic logic [7:0] expMask(input logic [7:0] idx);
    case (idx)
      8'h01: return 8'hD3;
      8'h02: return 8'h7F;
      8'h03, 8'h06, 8'h07: return 8'h1F;
      8'h05: return 8'hF3;
      8'h08: return 8'h0F;
      8'h09: return 8'h03;
      8'h12: return 8'hBB;
      8'h18: return 8'h77;
      8'h19: return 8'hFB;
      8'h1B: return 8'hEF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic wrPort(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(posedge clk); #1;
    ioWr = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] d);
    wrPort(16'h00F2, idx);
    wrPort(16'h00F3, d);
  endtask

  task automatic rdPort(input logic [15:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    ioAddr = a; ioRd = 1'b1;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
    ioRd = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wrPort(16'h00F2, idx);
    rdPort(16'h00F3, exp, tag);
  endtask

  task automatic lookup(input logic [19:0] a, input bit rd, input bit wr, input string tag);
    lookupAddr = a;
    #1;
    check(lookupRdInt == rd, {tag, " rd"}, lookupRdInt, rd);
    check(lookupWrInt == wr, {tag, " wr"}, lookupWrInt, wr);
  endtask

  // Monitor: compare every read against the scoreboard
  always @(negedge clk) begin
    if (rstN && ioRd) begin
      if (sbq.size() == 0) begin
        check(1'b0, "scoreboard underflow", ioRdData, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(ioRdData == it.exp, it.tag, ioRdData, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ioAddr = '0; ioWrData = '0; ioWr = 1'b0; ioRd = 1'b0;
    lookupAddr = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R5: reset state of outputs and every register
    check(extCacheEn == 1'b0, "R5 extCacheEn", extCacheEn, 0);
    check(intCacheEn == 1'b1, "R5 intCacheEn", intCacheEn, 1);
    check(shadowRdInt == 5'd0, "R5 shadowRdInt", shadowRdInt, 0);
    check(waitUpdate == 1'b0, "R5 waitUpdate", waitUpdate, 0);
    rdPort(16'h00F2, 8'h00, "R5 index");
    for (int i = 0; i < 256; i++) rdReg(8'(i), 8'h00, "R5 reg");

    // R1: index readback
    wrPort(16'h00F2, 8'h37);
    rdPort(16'h00F2, 8'h37, "R1 index readback");
    wrPort(16'h00F2, 8'hFF);
    rdPort(16'h00F2, 8'hFF, "R1 index max");

    // R3/R4: mask sweep over the low indices, plus gaps and the top index
    for (int i = 0; i < 32; i++) begin
      wrReg(8'(i), 8'hFF);
      rdPort(16'h00F3, expMask(8'(i)), (expMask(8'(i)) == 8'hFF) ? "R4 full byte" : "R3 masked");
    end
    wrReg(8'h12, 8'h5A); rdPort(16'h00F3, 8'h1A, "R3 reg12 pattern");
    wrReg(8'h80, 8'h5A); rdPort(16'h00F3, 8'h5A, "R4 reg80");
    wrReg(8'hFF, 8'hA5); rdPort(16'h00F3, 8'hA5, "R4 regFF");
    rdPort(16'h00F2, 8'hFF, "R2 index after data write");

    // R9: wait strobe
    wrReg(8'h01, 8'h00);
    check(waitUpdate == 1'b1, "R9 pulse reg01", waitUpdate, 1);
    @(posedge clk); #1;
    check(waitUpdate == 1'b0, "R9 pulse ends", waitUpdate, 0);
    wrReg(8'h02, 8'h00);
    check(waitUpdate == 1'b0, "R9 no pulse reg02", waitUpdate, 0);
    wrReg(8'h1A, 8'h00);
    check(waitUpdate == 1'b1, "R9 pulse reg1A", waitUpdate, 1);
    wrPort(16'h00F2, 8'h04);
    check(waitUpdate == 1'b0, "R9 no pulse index write", waitUpdate, 0);

    // R8: cache enables
    wrReg(8'h04, 8'h01);
    check(waitUpdate == 1'b1, "R9 pulse reg04", waitUpdate, 1);
    check(extCacheEn == 1'b1, "R8 ext on", extCacheEn, 1);
    wrReg(8'h04, 8'hFE);
    check(extCacheEn == 1'b0, "R8 ext off", extCacheEn, 0);
    wrReg(8'h1A, 8'h40);
    check(intCacheEn == 1'b0, "R8 int off", intCacheEn, 0);
    wrReg(8'h1A, 8'hBF);
    check(intCacheEn == 1'b1, "R8 int on", intCacheEn, 1);

    // R6/R7: shadow attributes, write protect clear
    wrReg(8'h02, 8'h15);
    check(shadowRdInt == 5'b10101, "R6 rd attr", shadowRdInt, 5'b10101);
    check(shadowWrInt == 5'b10101, "R7 wr attr", shadowWrInt, 5'b10101);
    lookup(20'hC0000, 1, 1, "R6 C0000");
    lookup(20'hC7FFF, 1, 1, "R6 C7FFF");
    lookup(20'hC8000, 0, 0, "R7 C8000 disabled");
    lookup(20'hD1234, 1, 1, "R6 D1234");
    lookup(20'hEFFFF, 0, 0, "R7 EFFFF disabled");
    lookup(20'hFFFFF, 1, 1, "R6 FFFFF");

    // R7: write protect
    wrReg(8'h02, 8'hFF);
    rdPort(16'h00F3, 8'h7F, "R3 reg02 mask");
    check(shadowRdInt == 5'b11111, "R6 all rd", shadowRdInt, 5'b11111);
    check(shadowWrInt == 5'b00000, "R7 protected", shadowWrInt, 0);
    lookup(20'hC8000, 1, 0, "R7 C8000 protected");
    lookup(20'hE0000, 1, 0, "R7 E0000 protected");

    // R10: below the window
    lookup(20'hBFFFF, 0, 0, "R10 BFFFF");
    lookup(20'h00000, 0, 0, "R10 00000");
    lookup(20'hA0000, 0, 0, "R10 A0000");

    // R11: index writes and foreign addresses leave registers alone
    wrReg(8'h0B, 8'h3C);
    wrPort(16'h00F2, 8'h0C);
    wrPort(16'h00F2, 8'h0B);
    rdPort(16'h00F3, 8'h3C, "R11 after index writes");
    wrPort(16'h00F1, 8'h99);
    wrPort(16'h00F4, 8'h99);
    wrPort(16'h01F3, 8'h99);
    rdPort(16'h00F3, 8'h3C, "R11 foreign writes");
    rdPort(16'h00F2, 8'h0B, "R11 index kept");
    rdPort(16'h00F1, 8'h00, "R11 foreign read");
    check(shadowRdInt == 5'b11111, "R11 shadow kept", shadowRdInt, 5'b11111);

    // R12: reads have no side effects
    rdPort(16'h00F3, 8'h3C, "R12 reread 1");
    rdPort(16'h00F3, 8'h3C, "R12 reread 2");
    rdPort(16'h00F2, 8'h0B, "R12 index after reads");
    rdReg(8'hFF, 8'hA5, "R2 select regFF");

    repeat (3) @(posedge clk);
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule